// File: doc/BRIEF.md
# Banked-Stack-Pointer General Register File

This block holds the processor's eight 16-bit general registers and connects them to the shared data bus. Each cycle the control sequencer presents a 5-bit source address. When that address falls inside the block's window of eight addresses, the block drives the selected register onto its read port and raises an output enable. Otherwise it releases the bus. On the write side, a 3-bit destination index and a write strobe latch the bus word into one register at the next clock edge. Register 7 is the program counter and register 6 is the stack pointer. Both are written and read like any other register.

The block also keeps a hidden saved-stack-pointer register and the current privilege mode. A transition pulse, together with a direction bit, exchanges register 6 with the saved register. Entering kernel mode therefore loads the kernel stack pointer and parks the user one. Returning does the reverse. A pulse that asks for the mode already in force is ignored. The block has no operand latches of its own.

Top module: `regbank_kstack`

## Requirements
- R1: Synchronous active-low reset clears all eight registers and the saved stack pointer to zero and places the block in user mode. The first kernel entry after reset therefore loads register 6 with zero.
- R2: When `src_addr[4:3]` equals `BASE_ADDR[4:3]` (default window 8..15), `rd_oe` is 1 in the same cycle and `rd_data` carries register `src_addr[2:0]`.
- R3: When `src_addr` lies outside the window, `rd_oe` is 0 and `rd_data` is zero.
- R4: With `wr_en` = 1, register `wr_idx` takes `wr_data` at the next rising edge, and no other register changes.
- R5: With `wr_en` = 0, no register changes, whatever `wr_idx` and `wr_data` carry.
- R6: Register 7 (program counter) is written and read through the same ports as the others, at window offset 7.
- R7: A pulse on `mode_xfer` with `mode_to_kernel` = 1 while in user mode exchanges register 6 and the saved stack pointer, and enters kernel mode.
- R8: A pulse on `mode_xfer` with `mode_to_kernel` = 0 while in kernel mode exchanges register 6 and the saved stack pointer, and returns to user mode.
- R9: A `mode_xfer` pulse whose direction equals the current mode changes neither register 6 nor the saved stack pointer.
- R10: In a cycle that performs an exchange, a bus write to register 6 is discarded and a bus write to any other register takes effect. When the pulse is redundant (R9), a write to register 6 takes effect.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| src_addr | input | 5 | Bus source address |
| rd_data | output | 16 | Selected register value, zero when not enabled |
| rd_oe | output | 1 | Bus output enable for this block |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Destination register index |
| wr_data | input | 16 | Bus word to latch |
| mode_xfer | input | 1 | One-cycle mode-transition pulse |
| mode_to_kernel | input | 1 | Transition direction: 1 into kernel, 0 back to user |

## Verification
The clocked assertions treat `mode_xfer` as a pulse that is valid only together with its direction bit, and `wr_idx` as meaningful only while `wr_en` is high. They do not require the two strobes to be exclusive. The stimulus drives every strobe for exactly one cycle, starting just after a rising edge. It deliberately overlaps mode pulses with writes to register 6 and to other registers. It also issues redundant pulses in both modes, so the priority and ignore rules are exercised within those assumptions.

// File: rtl/regbank_pkg.sv
// Package: shared constants and types for the banked register file.
// Assumes: the stack-pointer and program-counter indices are fixed by the sequencer.
package regbank_pkg;
    localparam int unsigned RB_WORD_W = 16;
    localparam int unsigned RB_NREG   = 8;
    localparam int unsigned RB_SRC_W  = 5;
    localparam int unsigned RB_SP_IDX = 6;
    localparam int unsigned RB_PC_IDX = 7;

    // Privilege mode held beside the stack pointer
    typedef enum logic {
        MODE_USER   = 1'b0,
        MODE_KERNEL = 1'b1
    } priv_mode_e;
endpackage

// File: rtl/rb_write_dec.sv
// Module: rb_write_dec
// Turns the destination index and strobe into one write enable per register.
// The stack-pointer enable is blocked while an exchange is in progress.
// Assumes: swap_i is already qualified by the mode state.
module rb_write_dec #(
    parameter int unsigned NREG   = 8,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned SP_IDX = 6
) (
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             swap_i,
    output logic [NREG-1:0]  we_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        if (i == SP_IDX) begin : g_sp
            assign we_o[i] = wr_en_i && (wr_idx_i == MY_IDX) && !swap_i;
        end else begin : g_gp
            assign we_o[i] = wr_en_i && (wr_idx_i == MY_IDX);
        end
    end

    // Checks that at most one register is enabled per cycle
    always_comb begin
        // R4
        we_onehot_chk: assert ($onehot0(we_o));
    end
endmodule

// File: rtl/rb_gp_cell.sv
// Module: rb_gp_cell
// One plain general register with a synchronous write enable.
// Assumes: the enable is already decoded and one-hot across cells.
module rb_gp_cell #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    // Holds the register word, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n)    q_r <= '0;
        else if (we_i) q_r <= d_i;
    end

    assign q_o = q_r;

    // R4
    gp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (q_o == $past(d_i)));

    // R5
    gp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q_o));
endmodule

// File: rtl/rb_sp_cell.sv
// Module: rb_sp_cell
// Stack-pointer register with a hidden saved copy and the privilege mode flag.
// A transition pulse that changes the mode exchanges the two words.
// Assumes: the write enable arrives already masked by swap_o.
module rb_sp_cell #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    input  logic         xfer_i,
    input  logic         to_kernel_i,
    output logic         swap_o,
    output logic [W-1:0] q_o
);
    import regbank_pkg::*;

    logic [W-1:0] sp_r;
    logic [W-1:0] saved_r;
    priv_mode_e   mode_r;
    priv_mode_e   mode_req;

    assign mode_req = to_kernel_i ? MODE_KERNEL : MODE_USER;

    // An exchange happens only when the requested mode differs from the present one
    assign swap_o = xfer_i && (mode_req != mode_r);

    // Keeps the live stack pointer, its saved copy and the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_r    <= '0;
            saved_r <= '0;
            mode_r  <= MODE_USER;
        end else if (swap_o) begin
            sp_r    <= saved_r;
            saved_r <= sp_r;
            mode_r  <= mode_req;
        end else if (we_i) begin
            sp_r    <= d_i;
        end
    end

    assign q_o = sp_r;

    // R7
    sp_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |=> (sp_r == $past(saved_r)) && (saved_r == $past(sp_r)));

    // R9
    saved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_o |=> $stable(saved_r) && $stable(mode_r));

    // R8
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> (mode_r == $past(mode_req)));

    // R10
    sp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !swap_o) |=> (sp_r == $past(d_i)));
endmodule

// File: rtl/rb_read_sel.sv
// Module: rb_read_sel
// Decodes the source address against this block's window and picks one register.
// Assumes: the window is aligned to the register count.
module rb_read_sel #(
    parameter int unsigned W     = 16,
    parameter int unsigned NREG  = 8,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned SRC_W = 5,
    parameter logic [SRC_W-1:0] BASE_ADDR = 5'd8
) (
    input  logic [SRC_W-1:0] src_addr_i,
    input  logic [W-1:0]     regs_i [NREG],
    output logic [W-1:0]     rd_data_o,
    output logic             rd_oe_o
);
    localparam int unsigned TAG_W = SRC_W - IDX_W;

    logic [TAG_W-1:0] addr_tag;
    logic [IDX_W-1:0] addr_idx;

    assign addr_tag = src_addr_i[SRC_W-1:IDX_W];
    assign addr_idx = src_addr_i[IDX_W-1:0];

    // Enables the bus driver and gates the selected word
    always_comb begin
        rd_oe_o   = (addr_tag == BASE_ADDR[SRC_W-1:IDX_W]);
        rd_data_o = rd_oe_o ? regs_i[addr_idx] : '0;
    end
endmodule

// File: rtl/regbank_kstack.sv
// Module: regbank_kstack (top)
// Eight bus-attached general registers. The stack-pointer slot is banked
// against a saved copy on privilege transitions. It has no operand latches.
// Assumes: mode_xfer and wr_en are single-cycle strobes from the sequencer.
module regbank_kstack #(
    parameter int unsigned W      = regbank_pkg::RB_WORD_W,
    parameter int unsigned NREG   = regbank_pkg::RB_NREG,
    parameter int unsigned SRC_W  = regbank_pkg::RB_SRC_W,
    parameter int unsigned SP_IDX = regbank_pkg::RB_SP_IDX,
    parameter logic [SRC_W-1:0] BASE_ADDR = 5'd8,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_addr,
    output logic [W-1:0]     rd_data,
    output logic             rd_oe,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic             mode_xfer,
    input  logic             mode_to_kernel
);
    logic [NREG-1:0] we;
    logic            swap;
    logic [W-1:0]    regs [NREG];

    rb_write_dec #(
        .NREG   (NREG),
        .IDX_W  (IDX_W),
        .SP_IDX (SP_IDX)
    ) u_wdec (
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .swap_i   (swap),
        .we_o     (we)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == SP_IDX) begin : g_sp
            rb_sp_cell #(.W(W)) u_sp (
                .clk         (clk),
                .rst_n       (rst_n),
                .we_i        (we[i]),
                .d_i         (wr_data),
                .xfer_i      (mode_xfer),
                .to_kernel_i (mode_to_kernel),
                .swap_o      (swap),
                .q_o         (regs[i])
            );
        end else begin : g_gp
            rb_gp_cell #(.W(W)) u_gp (
                .clk   (clk),
                .rst_n (rst_n),
                .we_i  (we[i]),
                .d_i   (wr_data),
                .q_o   (regs[i])
            );
        end
    end

    rb_read_sel #(
        .W         (W),
        .NREG      (NREG),
        .IDX_W     (IDX_W),
        .SRC_W     (SRC_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_rsel (
        .src_addr_i (src_addr),
        .regs_i     (regs),
        .rd_data_o  (rd_data),
        .rd_oe_o    (rd_oe)
    );

    // R10
    sp_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && wr_en && (wr_idx == IDX_W'(SP_IDX))) |-> !we[SP_IDX]);
endmodule

// File: tb/regbank_kstack_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected reads, a monitor pops and compares.
module regbank_kstack_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_addr = '0;
    logic [15:0] rd_data;
    logic        rd_oe;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        mode_xfer = 1'b0;
    logic        mode_to_kernel = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit timed_out = 0;

    typedef struct {
        logic [4:0]  addr;
        logic        oe;
        logic [15:0] data;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    logic [15:0] m_reg [8];
    logic [15:0] m_saved;
    bit          m_kern;

    always #2 clk = ~clk;

    regbank_kstack dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .src_addr       (src_addr),
        .rd_data        (rd_data),
        .rd_oe          (rd_oe),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_data        (wr_data),
        .mode_xfer      (mode_xfer),
        .mode_to_kernel (mode_to_kernel)
    );

    // Monitor: compares the read port at the falling edge against the queued item
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (rd_oe !== e.oe || rd_data !== e.data) begin
                n_bad++;
                $display("FAIL %s addr=%0d got oe=%b data=%h exp oe=%b data=%h",
                         e.tag, e.addr, rd_oe, rd_data, e.oe, e.data);
            end
        end
    end

    // Driver: present one source address and queue the expected result
    task automatic rd(input logic [4:0] a, input string tag);
        exp_t e;
        @(posedge clk); #1;
        src_addr = a;
        e.addr = a;
        e.oe   = (a[4:3] == 2'b01);
        e.data = e.oe ? m_reg[a[2:0]] : 16'h0;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Driver: one cycle of write and optional mode pulse, model updated alongside
    task automatic cyc(input bit we, input logic [2:0] idx, input logic [15:0] d,
                       input bit xf, input bit tok);
        bit sw;
        @(posedge clk); #1;
        wr_en = we; wr_idx = idx; wr_data = d;
        mode_xfer = xf; mode_to_kernel = tok;
        sw = xf && (tok != m_kern);
        if (sw) begin
            logic [15:0] t;
            t = m_reg[6]; m_reg[6] = m_saved; m_saved = t; m_kern = tok;
        end
        if (we && !(sw && idx == 3'd6)) m_reg[idx] = d;
        @(posedge clk); #1;
        wr_en = 1'b0; mode_xfer = 1'b0;
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 8; i++) rd(5'(8 + i), tag);
    endtask

    task automatic stimulus();
        for (int i = 0; i < 8; i++) m_reg[i] = 16'h0;
        m_saved = 16'h0; m_kern = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd_all("R1 reset");
        rd(5'd0, "R3 low"); rd(5'd7, "R3 below"); rd(5'd16, "R3 above"); rd(5'd31, "R3 top");
        for (int i = 0; i < 8; i++) cyc(1, 3'(i), 16'h1000 + 16'(i) * 16'h0111, 0, 0);
        rd_all("R2 R4 fill");
        rd(5'd15, "R6 pc");
        cyc(1, 3'd7, 16'h4A00, 0, 0);
        rd(5'd15, "R6 pc write");
        rd(5'd8, "R4 others kept");
        @(posedge clk); #1 wr_en = 1'b0; wr_idx = 3'd3; wr_data = 16'hFFFF;
        @(posedge clk); #1;
        rd(5'd11, "R5 no strobe");
        cyc(0, 3'd0, 16'h0, 1, 1);
        rd(5'd14, "R7 R1 entry loads zero");
        rd(5'd13, "R7 others kept");
        cyc(1, 3'd6, 16'h1234, 1, 1);
        rd(5'd14, "R9 R10 redundant entry write");
        cyc(1, 3'd6, 16'hDEAD, 1, 0);
        rd(5'd14, "R8 R10 return drops write");
        cyc(1, 3'd2, 16'h2222, 1, 1);
        rd(5'd14, "R7 reentry");
        rd(5'd10, "R10 other write applies");
        cyc(0, 3'd0, 16'h0, 1, 0);
        rd(5'd14, "R8 return");
        cyc(0, 3'd0, 16'h0, 1, 0);
        rd(5'd14, "R9 redundant return");
        cyc(0, 3'd0, 16'h0, 1, 1);
        rd(5'd14, "R9 saved unchanged");
        rd_all("R4 final");
        rd(5'd3, "R3 final");
        repeat (3) @(posedge clk);
    endtask

    initial begin
        fork
            stimulus();
            begin
                repeat (5000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_bad++;
            $display("FAIL watchdog expired");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule